// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache Lookup

This unit is the read path of a small set-associative cache. It splits a byte address into a tag, a set number and a byte offset. It reads the selected set and compares the tag of every way in that set at the same time. It returns a hit flag together with the word held by the matching way. When no way matches, it asks a memory-side responder for the word. It stalls new lookups until that word arrives. It then writes the word into a victim way and returns it as the result.

Lookups arrive on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a refill is outstanding, `req_ready` stays low. A requester must then hold its request, or drop it, until ready rises again. The result comes back as a one-cycle `rsp_valid` pulse and cannot be back-pressured. The memory side uses a level request (`fill_req_valid` with the block address) and a one-cycle answer (`fill_rsp_valid` with the word).

Replacement is true least-recently-used within each set. Every hit and every refill makes the accessed way the most recent one. The number of ways, the number of sets and the widths are parameters. A two-way, two-set build is used as a second configuration.

Top module: `assoc_lookup_cache`

## Requirements
- R1: The address is split with bits 1..0 as the byte offset, bits 9..2 as the set number and bits 31..10 as the tag. The set number is the block address (address bits 31..2) modulo the 256 sets. The byte offset has no effect on the outcome or the data.
- R2: A way matches only when its valid bit is set and its stored tag equals the request tag. After reset every way is invalid, so the first access to any address misses.
- R3: A request accepted with a match gives, on the next clock edge, a one-cycle `rsp_valid` with `rsp_hit`=1 and `rsp_data` equal to the word held by the matching way.
- R4: A request accepted without a match sets `fill_req_valid` on the next edge, with `fill_req_addr` equal to address bits 31..2. Both stay steady until `fill_rsp_valid`. `req_ready` stays low for the whole wait and `rsp_valid` stays low.
- R5: The edge that samples `fill_rsp_valid` while a refill is pending stores the word. It drives, for one cycle, `rsp_valid`=1, `rsp_hit`=0 and `rsp_data` equal to the refill word. On the same edge it drops `fill_req_valid` and raises `req_ready`.
- R6: While a set holds fewer valid lines than it has ways, a miss in that set fills an invalid way (the lowest-numbered one) and evicts no valid line.
- R7: A miss in a full set replaces the line whose last hit or refill is the oldest in that set.
- R8: After reset: `req_ready`=1, `rsp_valid`=0 and `fill_req_valid`=0. Each set's age order starts with way 0 oldest.
- R9: In a two-way build with two sets, block addresses 0, 8, 0, 6, 8 (all in set 0) give miss, miss, hit, miss, miss.
- R10: A request is taken only on an edge where `req_valid` and `req_ready` are both high. The result is a single `rsp_valid` pulse for each request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can take a lookup |
| req_addr | input | 32 | Byte address of the lookup |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Result came from a matching way |
| rsp_data | output | 32 | Result word |
| fill_req_valid | output | 1 | Refill wanted (held until answered) |
| fill_req_addr | output | 30 | Block address of the refill |
| fill_rsp_valid | input | 1 | Refill word present |
| fill_rsp_data | input | 32 | Refill word |

## Verification
Directed patterns come first. A cold miss followed by hits at every byte offset tests the address split. Four tags in one set test that no valid line is evicted while free ways remain. A reordering of hits followed by a fifth tag tells true LRU apart from fill order or round-robin. A long pseudo-random sweep then covers a few sets and a small tag pool with varied refill latency, so evictions, re-fetches and modulo aliasing (sets 0 and 255) mix freely. A bench model based on timestamps predicts every hit and miss. Each stored word depends on its full block address, so a wrong way in the select multiplexer shows up as bad data. The two-way build replays the five-access sequence whose pattern separates LRU from other replacement choices.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/tag_compare_bank.sv
module tag_compare_bank #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WAYS-1:0]               way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]    way_tag,
  input  logic [WAYS-1:0][DATA_W-1:0]   way_dat,
  input  logic [TAG_W-1:0]              look_tag,
  output logic [WAYS-1:0]               match,
  output logic                          hit,
  output logic [WAY_W-1:0]              hit_way,
  output logic [DATA_W-1:0]             hit_data
);
  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = way_vld[g] && (way_tag[g] == look_tag);
    end
  endgenerate

  assign hit = |match;

  always_comb begin
    hit_way  = '0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        hit_way  = WAY_W'(w);
      end
      hit_data = hit_data | (way_dat[w] & {DATA_W{match[w]}});
    end
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/lru_order_update.sv
module lru_order_update #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][WAY_W-1:0] cur_rank,
  input  logic [WAY_W-1:0]           acc_way,
  output logic [WAYS-1:0][WAY_W-1:0] nxt_rank
);
  localparam logic [WAY_W-1:0] NEWEST = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] acc_rank;
  assign acc_rank = cur_rank[acc_way];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == acc_way) begin
        nxt_rank[w] = NEWEST;
      end else if (cur_rank[w] > acc_rank) begin
        nxt_rank[w] = cur_rank[w] - 1'b1;
      end else begin
        nxt_rank[w] = cur_rank[w];
      end
    end
  end
endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0]            way_vld,
  input  logic [WAYS-1:0][WAY_W-1:0] rank,
  output logic [WAY_W-1:0]           victim
);
  logic [WAYS-1:0] is_oldest;
  logic            full;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_old
      assign is_oldest[g] = (rank[g] == '0);
    end
  endgenerate

  assign full = &way_vld;

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && (full ? is_oldest[w] : !way_vld[w])) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end

  // R7
  lru_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> ($countones(is_oldest) == 1));
endmodule

// File: rtl/assoc_lookup_cache.sv
module assoc_lookup_cache
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WAYS     = 4,
  parameter int SET_BITS = 8,
  parameter int OFF_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [DATA_W-1:0]          rsp_data,
  output logic                       fill_req_valid,
  output logic [ADDR_W-OFF_BITS-1:0] fill_req_addr,
  input  logic                       fill_rsp_valid,
  input  logic [DATA_W-1:0]          fill_rsp_data
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
  localparam int BLK_W = ADDR_W - OFF_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  ctl_state_e state_q;
  logic [BLK_W-1:0] held_blk_q;

  logic [WAYS-1:0]                 vld_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]      tag_q [SETS];
  logic [WAYS-1:0][DATA_W-1:0]     dat_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0]      rnk_q [SETS];

  logic unused_offset;
  assign unused_offset = ^req_addr[OFF_BITS-1:0];

  logic [BLK_W-1:0]    cur_blk;
  logic [SET_BITS-1:0] sel_set;
  logic [TAG_W-1:0]    cur_tag;
  assign cur_blk = (state_q == ST_LOOKUP) ? req_addr[ADDR_W-1:OFF_BITS] : held_blk_q;
  assign sel_set = cur_blk[SET_BITS-1:0];
  assign cur_tag = cur_blk[BLK_W-1:SET_BITS];

  logic [WAYS-1:0]   match;
  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [DATA_W-1:0] hit_data;
  logic [WAY_W-1:0]  vict_way;
  logic [WAY_W-1:0]  upd_way;
  logic [WAYS-1:0][WAY_W-1:0] nxt_rank;

  tag_compare_bank #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) cmp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .way_vld  (vld_q[sel_set]),
    .way_tag  (tag_q[sel_set]),
    .way_dat  (dat_q[sel_set]),
    .look_tag (cur_tag),
    .match    (match),
    .hit      (hit),
    .hit_way  (hit_way),
    .hit_data (hit_data)
  );

  victim_pick #(.WAYS(WAYS)) vic_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .way_vld (vld_q[sel_set]),
    .rank    (rnk_q[sel_set]),
    .victim  (vict_way)
  );

  lru_order_update #(.WAYS(WAYS)) lru_i (
    .cur_rank (rnk_q[sel_set]),
    .acc_way  (upd_way),
    .nxt_rank (nxt_rank)
  );

  logic acc_fire;
  logic fill_done;
  assign req_ready      = (state_q == ST_LOOKUP);
  assign acc_fire       = req_valid && req_ready;
  assign fill_done      = (state_q == ST_REFILL) && fill_rsp_valid;
  assign upd_way        = fill_done ? vict_way : hit_way;
  assign fill_req_valid = (state_q == ST_REFILL);
  assign fill_req_addr  = held_blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_LOOKUP;
      held_blk_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_data   <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          rnk_q[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_LOOKUP: begin
          if (acc_fire) begin
            if (hit) begin
              rsp_valid      <= 1'b1;
              rsp_hit        <= 1'b1;
              rsp_data       <= hit_data;
              rnk_q[sel_set] <= nxt_rank;
            end else begin
              held_blk_q <= req_addr[ADDR_W-1:OFF_BITS];
              state_q    <= ST_REFILL;
            end
          end
        end
        ST_REFILL: begin
          if (fill_rsp_valid) begin
            vld_q[sel_set][vict_way] <= 1'b1;
            rnk_q[sel_set]           <= nxt_rank;
            rsp_valid                <= 1'b1;
            rsp_hit                  <= 1'b0;
            rsp_data                 <= fill_rsp_data;
            state_q                  <= ST_LOOKUP;
          end
        end
        default: state_q <= ST_LOOKUP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      tag_q[sel_set][vict_way] <= cur_tag;
      dat_q[sel_set][vict_way] <= fill_rsp_data;
    end
  end

  // R4
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_rsp_valid) |=> (fill_req_valid && $stable(fill_req_addr)));

  // R4
  refill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req_valid) |-> $past(req_valid && req_ready));

  // R5
  refill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && fill_rsp_valid) |=> (rsp_valid && !rsp_hit && req_ready));

  // R3
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready));
endmodule

// File: tb/assoc_lookup_cache_tb_top.sv
`timescale 1ns/1ps
module assoc_lookup_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // main 4-way, 256-set build
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic        fill_req_valid;
  logic [29:0] fill_req_addr;
  logic        fill_rsp_valid = 1'b0;
  logic [31:0] fill_rsp_data = '0;

  assoc_lookup_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data)
  );

  // reduced 2-way, 2-set build
  logic        s_req_valid = 1'b0;
  logic        s_req_ready;
  logic [31:0] s_req_addr = '0;
  logic        s_rsp_valid, s_rsp_hit;
  logic [31:0] s_rsp_data;
  logic        s_fill_req_valid;
  logic [29:0] s_fill_req_addr;
  logic        s_fill_rsp_valid = 1'b0;
  logic [31:0] s_fill_rsp_data = '0;

  assoc_lookup_cache #(.WAYS(2), .SET_BITS(1)) dut_small_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(s_req_valid), .req_ready(s_req_ready), .req_addr(s_req_addr),
    .rsp_valid(s_rsp_valid), .rsp_hit(s_rsp_hit), .rsp_data(s_rsp_data),
    .fill_req_valid(s_fill_req_valid), .fill_req_addr(s_fill_req_addr),
    .fill_rsp_valid(s_fill_rsp_valid), .fill_rsp_data(s_fill_rsp_data)
  );

  function automatic logic [31:0] mem_word(input logic [29:0] blk);
    return {blk[13:0], blk[29:12]} ^ 32'hC3A5_1E0F ^ {2'b00, blk};
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // bench model: per set, up to 4 tags with last-use stamps
  bit          m_v [256][4];
  logic [21:0] m_t [256][4];
  int          m_s [256][4];
  int          stamp = 0;

  function automatic int model_find(input logic [7:0] s, input logic [21:0] t);
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_t[s][w] == t) return w;
    return -1;
  endfunction

  // returns 1 for hit; updates model
  function automatic bit model_access(input logic [31:0] a);
    logic [7:0]  s = a[9:2];
    logic [21:0] t = a[31:10];
    int f = model_find(s, t);
    int v = -1;
    stamp++;
    if (f >= 0) begin
      m_s[s][f] = stamp;
      return 1'b1;
    end
    for (int w = 0; w < 4; w++) if (v < 0 && !m_v[s][w]) v = w;
    if (v < 0) begin
      v = 0;
      for (int w = 1; w < 4; w++) if (m_s[s][w] < m_s[s][v]) v = w;
    end
    m_v[s][v] = 1'b1;
    m_t[s][v] = t;
    m_s[s][v] = stamp;
    return 1'b0;
  endfunction

  task automatic access(input logic [31:0] a, input int lat, input string rq);
    bit eh = model_access(a);
    @(negedge clk);
    chk("R10", "ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (eh) begin
      chk(rq, "hit flag", {30'b0, rsp_valid, rsp_hit}, 32'd3);
      chk(rq, "hit data", rsp_data, mem_word(a[31:2]));
    end else begin
      chk(rq, "miss: no result yet", {31'b0, rsp_valid}, 32'd0);
      chk("R4", "refill request", {1'b0, fill_req_valid, fill_req_addr}, {2'b01, a[31:2]});
      chk("R4", "stall ready", {31'b0, req_ready}, 32'd0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk("R4", "refill held", {1'b0, fill_req_valid, fill_req_addr}, {2'b01, a[31:2]});
      end
      fill_rsp_valid = 1'b1;
      fill_rsp_data  = mem_word(a[31:2]);
      @(negedge clk);
      fill_rsp_valid = 1'b0;
      fill_rsp_data  = '0;
      chk("R5", "miss result", {29'b0, rsp_valid, rsp_hit, req_ready}, 32'd5);
      chk("R5", "miss data", rsp_data, mem_word(a[31:2]));
      chk("R5", "refill dropped", {31'b0, fill_req_valid}, 32'd0);
    end
  endtask

  task automatic small_access(input logic [29:0] blk, input bit exp_hit, input int idx);
    @(negedge clk);
    s_req_valid = 1'b1;
    s_req_addr  = {blk, 2'b00};
    @(negedge clk);
    s_req_valid = 1'b0;
    if (!exp_hit) begin
      chk("R9", $sformatf("access %0d waits", idx), {31'b0, s_fill_req_valid}, 32'd1);
      s_fill_rsp_valid = 1'b1;
      s_fill_rsp_data  = mem_word(blk);
      @(negedge clk);
      s_fill_rsp_valid = 1'b0;
    end
    chk("R9", $sformatf("access %0d outcome", idx),
        {30'b0, s_rsp_valid, s_rsp_hit}, {30'b0, 1'b1, exp_hit});
    chk("R9", $sformatf("access %0d data", idx), s_rsp_data, mem_word(blk));
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8", "reset outputs", {29'b0, req_ready, rsp_valid, fill_req_valid}, 32'd4);
    chk("R8", "reset outputs small", {30'b0, s_req_ready, s_rsp_valid}, 32'd2);

    // R2: cold miss, then R1: all byte offsets hit the same word
    access(32'h1234_5678, 0, "R2");
    for (int o = 0; o < 4; o++) access({30'h048D_159E, o[1:0]}, 0, "R1");
    // R1: same set via block + 256 (set modulo), different tag misses
    access(32'h1234_5678 + 32'h400, 2, "R1");
    access(32'h1234_5678, 0, "R1");

    // R6: four tags into set 7, none evicted
    for (int t = 0; t < 4; t++) access({22'(t + 100), 8'd7, 2'b00}, t, "R6");
    for (int t = 0; t < 4; t++) access({22'(t + 100), 8'd7, 2'b01}, 0, "R6");
    // R7: reorder: touch 102,100,103 -> 101 is oldest
    access({22'd102, 8'd7, 2'b00}, 0, "R7");
    access({22'd100, 8'd7, 2'b00}, 0, "R7");
    access({22'd103, 8'd7, 2'b00}, 0, "R7");
    access({22'd200, 8'd7, 2'b00}, 1, "R7");   // evicts tag 101
    access({22'd102, 8'd7, 2'b00}, 0, "R7");   // still present
    access({22'd101, 8'd7, 2'b00}, 0, "R7");   // miss, evicts tag 100
    access({22'd100, 8'd7, 2'b00}, 3, "R7");   // miss

    // near-exhaustive sweep: small tag pool, aliasing sets, varied latency
    lcg = 32'h1F2E_3D4C;
    for (int i = 0; i < 600; i++) begin
      logic [7:0] st;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      case (lcg[25:24])
        2'd0: st = 8'd0;
        2'd1: st = 8'd1;
        2'd2: st = 8'd255;
        default: st = 8'd7;
      endcase
      access({22'(lcg[30:28] + 22'd300), st, lcg[3:2]}, i % 4, "R7");
    end

    // R9: reduced build, blocks 0,8,0,6,8
    small_access(30'd0, 1'b0, 0);
    small_access(30'd8, 1'b0, 1);
    small_access(30'd0, 1'b1, 2);
    small_access(30'd6, 1'b0, 3);
    small_access(30'd8, 1'b0, 4);

    // R10: request with valid low is not taken
    @(negedge clk);
    req_addr = 32'hDEAD_0000;
    @(negedge clk);
    chk("R10", "idle no result", {30'b0, rsp_valid, fill_req_valid}, 32'd0);

    finish_run();
  end
endmodule